// File: doc/BRIEF.md
# SMBus indexed block register slave

This block is a two-wire bus slave that fronts a 32-byte control register file. The bus clock and data lines are resampled in a fast system clock. The slave finds start, repeated start and stop conditions, shifts address, command and data bits, and drives the data line only through an open-drain pull-down enable. All register contents leave the block on a flat parallel port for the logic that the registers control.

Every transfer is indexed. A write names a starting register and a byte count, then sends that many bytes. A read first names the starting register in a short write phase, then turns the bus around with a repeated start. The slave answers with a count byte, which lives in register 8, and then streams registers upward from the stored index until the master refuses a byte. The index wraps from the top register back to register 0.

Top module: `smb_regfile_slave`

## Requirements
- R1: After reset the pull-down enable `sda_oe` is 0, register 8 holds 08h and every other register i holds 40h + i.
- R2: The slave acknowledges the address byte D2h (write) and D3h (read) and no other; after any other address byte it leaves SDA released and ignores the bus until the next start.
- R3: A write transfer is D2h, a starting index byte, a count byte N and N data bytes; each of these bytes is acknowledged, the first data byte lands in the register at the index and each later one in the next higher register.
- R4: A count byte of 00h is not acknowledged and no register changes in that transfer.
- R5: Data bytes beyond the count N are not acknowledged and are not stored.
- R6: A read is D2h and the index byte, then a repeated start and D3h; the slave then sends register 8 first and then the registers from the index upward, most significant bit first.
- R7: When the master does not acknowledge a read byte, the slave releases SDA before the next bit and stays idle; a stop after any number of read bytes ends the read with SDA released.
- R8: The register index wraps from 31 to 0 on both writes and reads.
- R9: A start or stop condition in the middle of a byte aborts the transfer; the partial byte is not stored and the next transfer runs normally.
- R10: A bus write to register 8 changes the count byte that later reads return.
- R11: The slave changes its pull-down enable only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| regs_o | output | NREGS*8 | Register i on bits [8i+7:8i] |

## Verification
The hardest situations to reach are the ones where the master walks away from a transfer at an awkward moment: a stop after only a few bits of a data byte, or a refused read byte after which the slave must not keep driving. The bench drives the bus at bit level with its own open-drain model, so a task can break off after any number of bits and issue a stop, and it checks the pull-down enable between the master's refusal and the stop. Index wrap is reached by starting transfers at registers 30 and 31.

// File: rtl/smb_regfile_slave.sv
module smb_regfile_slave #(
  parameter int NREGS = 32,
  parameter logic [7:0] WR_ADDR = 8'hD2,
  parameter logic [7:0] RD_ADDR = 8'hD3,
  parameter int CNT_REG = 8,
  parameter logic [7:0] CNT_DEFAULT = 8'h08,
  parameter logic [7:0] FILL_BASE = 8'h40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic [NREGS*8-1:0] regs_o
);
  localparam int AW = $clog2(NREGS);
  localparam logic [AW-1:0] CNT_IDX = AW'(CNT_REG);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} st_t;
  typedef enum logic [1:0] {P_ADDR, P_OFS, P_CNT, P_DATA} ph_t;

  logic [2:0] scl_q, sda_q;
  st_t st;
  ph_t ph;
  logic [7:0] shreg, left;
  logic [2:0] bitcnt;
  logic full, ack_pend, rd_mode, mack_ok;
  logic [AW-1:0] ptr;
  logic [7:0] mem [NREGS];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire scl_s = scl_q[1];
  wire scl_d = scl_q[2];
  wire sda_s = sda_q[1];
  wire sda_d = sda_q[2];
  wire start_c = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire [7:0] rx_byte = {shreg[6:0], sda_s};
  wire byte_done = (st == S_RX) && scl_rise && (bitcnt == 3'd7);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      ph <= P_ADDR;
      shreg <= '0;
      left <= '0;
      bitcnt <= '0;
      full <= 1'b0;
      ack_pend <= 1'b0;
      rd_mode <= 1'b0;
      mack_ok <= 1'b0;
      ptr <= '0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NREGS; i++)
        mem[i] <= (i == CNT_REG) ? CNT_DEFAULT : FILL_BASE + 8'(i);
    end else if (start_c) begin
      st <= S_RX;
      ph <= P_ADDR;
      bitcnt <= '0;
      full <= 1'b0;
      ack_pend <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE;
      full <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_RX:
          if (scl_rise) begin
            shreg <= rx_byte;
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              full <= 1'b1;
              ack_pend <= 1'b0;
              case (ph)
                P_ADDR:
                  if (rx_byte == WR_ADDR) begin
                    ack_pend <= 1'b1;
                    rd_mode <= 1'b0;
                    ph <= P_OFS;
                  end else if (rx_byte == RD_ADDR) begin
                    ack_pend <= 1'b1;
                    rd_mode <= 1'b1;
                  end
                P_OFS: begin
                  ptr <= rx_byte[AW-1:0];
                  ack_pend <= 1'b1;
                  ph <= P_CNT;
                end
                P_CNT:
                  if (rx_byte != 8'd0) begin
                    left <= rx_byte;
                    ack_pend <= 1'b1;
                    ph <= P_DATA;
                  end
                default:
                  if (left != 8'd0) begin
                    mem[ptr] <= rx_byte;
                    ptr <= ptr + AW'(1);
                    left <= left - 8'd1;
                    ack_pend <= 1'b1;
                  end
              endcase
            end
          end else if (scl_fall && full) begin
            full <= 1'b0;
            if (ack_pend) begin
              st <= S_ACK;
              sda_oe <= 1'b1;
            end else begin
              st <= S_IDLE;
            end
          end
        S_ACK:
          if (scl_fall) begin
            bitcnt <= '0;
            if (rd_mode) begin
              st <= S_TX;
              shreg <= mem[CNT_IDX];
              sda_oe <= ~mem[CNT_IDX][7];
            end else begin
              st <= S_RX;
              sda_oe <= 1'b0;
            end
          end
        S_TX:
          if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              sda_oe <= 1'b0;
              st <= S_MACK;
            end else begin
              shreg <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
              bitcnt <= bitcnt + 3'd1;
            end
          end
        S_MACK:
          if (scl_rise) begin
            mack_ok <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_ok) begin
              st <= S_TX;
              shreg <= mem[ptr];
              sda_oe <= ~mem[ptr][7];
              ptr <= ptr + AW'(1);
              bitcnt <= '0;
            end else begin
              st <= S_IDLE;
            end
          end
        default: ;
      endcase
    end

  for (genvar g = 0; g < NREGS; g++) begin : g_out
    assign regs_o[g*8 +: 8] = mem[g];
  end
endmodule

// File: rtl/smb_regfile_slave_chk.sv
module smb_regfile_slave_chk #(
  parameter int NREGS = 32,
  parameter logic [7:0] WR_ADDR = 8'hD2,
  parameter logic [7:0] RD_ADDR = 8'hD3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_s,
  input logic               scl_rise,
  input logic               stop_c,
  input logic               byte_done,
  input logic [7:0]         rx_byte,
  input logic [1:0]         ph,
  input logic               ack_pend,
  input logic               sda_oe,
  input logic [NREGS*8-1:0] regs_o
);
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s)); // R11
  AST_REG_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> $past(scl_rise)); // R3
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_oe); // R7
  AST_BAD_ADDR_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && ph == 2'd0 && rx_byte != WR_ADDR && rx_byte != RD_ADDR) |=> !ack_pend); // R2
  AST_ZERO_CNT_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && ph == 2'd2 && rx_byte == 8'd0) |=> (!ack_pend && $stable(regs_o))); // R4
endmodule

bind smb_regfile_slave smb_regfile_slave_chk #(
  .NREGS(NREGS), .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_rise(scl_rise), .stop_c(stop_c),
  .byte_done(byte_done), .rx_byte(rx_byte), .ph(ph), .ack_pend(ack_pend),
  .sda_oe(sda_oe), .regs_o(regs_o)
);

// File: tb/sim_smb_regfile_slave.sv
module sim_smb_regfile_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam int NREGS = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  logic [NREGS*8-1:0] regs_o;
  wire sda = ~(m_low | sda_oe);

  smb_regfile_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .sda_oe(sda_oe), .regs_o(regs_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  int oe_viol = 0;
  logic oe_prev = 1'b0;
  logic [7:0] expv [NREGS];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  logic ackv [12];
  logic oe_after_nack;

  always @(posedge clk) begin
    if (rst_n && scl && sda_oe !== oe_prev) oe_viol++;
    oe_prev <= sda_oe;
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    wait_clk(Q); m_low = 1'b0;
    wait_clk(Q); scl = 1'b1;
    wait_clk(Q); m_low = 1'b1;
    wait_clk(Q); scl = 1'b0;
  endtask

  task automatic bus_stop;
    wait_clk(Q); m_low = 1'b1;
    wait_clk(Q); scl = 1'b1;
    wait_clk(Q); m_low = 1'b0;
    wait_clk(2*Q);
  endtask

  task automatic put_bit(input logic b);
    wait_clk(Q); m_low = ~b;
    wait_clk(Q); scl = 1'b1;
    wait_clk(2*Q); scl = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    wait_clk(Q); m_low = 1'b0;
    wait_clk(Q); scl = 1'b1;
    wait_clk(Q); b = sda;
    wait_clk(Q); scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ackd);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ackd = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~mack);
  endtask

  task automatic write_block(input logic [7:0] ofs, input logic [7:0] cnt, input int nsend);
    bus_start;
    send_byte(8'hD2, ackv[0]);
    send_byte(ofs, ackv[1]);
    send_byte(cnt, ackv[2]);
    for (int i = 0; i < nsend; i++) send_byte(wbuf[i], ackv[3+i]);
    bus_stop;
  endtask

  task automatic read_block(input logic [7:0] ofs, input int ndata);
    bus_start;
    send_byte(8'hD2, ackv[0]);
    send_byte(ofs, ackv[1]);
    bus_start;
    send_byte(8'hD3, ackv[2]);
    for (int i = 0; i <= ndata; i++) recv_byte(rbuf[i], i != ndata);
    wait_clk(Q);
    oe_after_nack = sda_oe;
    bus_stop;
  endtask

  task automatic check_regs(input string tag);
    int bad = -1;
    for (int i = 0; i < NREGS; i++)
      if (bad < 0 && regs_o[i*8 +: 8] !== expv[i]) bad = i;
    if (bad < 0) check(1'b1, tag, 0, 0);
    else check(1'b0, $sformatf("%s reg%0d", tag, bad), {24'd0, regs_o[bad*8 +: 8]}, {24'd0, expv[bad]});
  endtask

  task automatic t_reset;
    for (int i = 0; i < NREGS; i++) expv[i] = (i == 8) ? 8'h08 : 8'h40 + 8'(i);
    check(sda_oe == 1'b0, "R1 oe after reset", {31'd0, sda_oe}, 0);
    check_regs("R1 defaults");
  endtask

  task automatic t_write;
    wbuf[0] = 8'hA1; wbuf[1] = 8'h5B; wbuf[2] = 8'hC3; wbuf[3] = 8'h0E;
    write_block(8'd3, 8'd4, 4);
    for (int i = 0; i < 7; i++) check(ackv[i] == 1'b1, $sformatf("R3 ack byte %0d", i), {31'd0, ackv[i]}, 1);
    for (int i = 0; i < 4; i++) expv[3+i] = wbuf[i];
    check_regs("R3 block write");
  endtask

  task automatic t_read;
    read_block(8'd3, 4);
    check(ackv[2] == 1'b1, "R2 read address acked", {31'd0, ackv[2]}, 1);
    check(rbuf[0] == expv[8], "R6 count byte", {24'd0, rbuf[0]}, {24'd0, expv[8]});
    for (int i = 0; i < 4; i++)
      check(rbuf[1+i] == expv[3+i], $sformatf("R6 data %0d", i), {24'd0, rbuf[1+i]}, {24'd0, expv[3+i]});
    check(oe_after_nack == 1'b0, "R7 released after nack", {31'd0, oe_after_nack}, 0);
  endtask

  task automatic t_bad_addr;
    logic a0, a1, a2;
    bus_start;
    send_byte(8'hA0, a0);
    send_byte(8'h02, a1);
    send_byte(8'h01, a2);
    bus_stop;
    check(a0 == 1'b0, "R2 foreign address nack", {31'd0, a0}, 0);
    check(a1 == 1'b0 && a2 == 1'b0, "R2 later bytes ignored", {30'd0, a1, a2}, 0);
    check_regs("R2 no change");
  endtask

  task automatic t_zero;
    wbuf[0] = 8'h77; wbuf[1] = 8'h66;
    write_block(8'd5, 8'd0, 2);
    check(ackv[2] == 1'b0, "R4 zero count nack", {31'd0, ackv[2]}, 0);
    check_regs("R4 no change");
  endtask

  task automatic t_excess;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    write_block(8'd10, 8'd2, 3);
    check(ackv[4] == 1'b1, "R5 last counted byte acked", {31'd0, ackv[4]}, 1);
    check(ackv[5] == 1'b0, "R5 extra byte nack", {31'd0, ackv[5]}, 0);
    expv[10] = 8'h11; expv[11] = 8'h22;
    check_regs("R5 extra not stored");
  endtask

  task automatic t_wrap;
    wbuf[0] = 8'hE0; wbuf[1] = 8'hE1; wbuf[2] = 8'hE2; wbuf[3] = 8'hE3;
    write_block(8'd30, 8'd4, 4);
    expv[30] = 8'hE0; expv[31] = 8'hE1; expv[0] = 8'hE2; expv[1] = 8'hE3;
    check_regs("R8 write wrap");
    read_block(8'd31, 2);
    check(rbuf[1] == 8'hE1 && rbuf[2] == 8'hE2, "R8 read wrap", {16'd0, rbuf[1], rbuf[2]}, 32'hE1E2);
  endtask

  task automatic t_count;
    wbuf[0] = 8'h03;
    write_block(8'd8, 8'd1, 1);
    expv[8] = 8'h03;
    check_regs("R10 single byte write");
    read_block(8'd0, 1);
    check(rbuf[0] == 8'h03, "R10 new count returned", {24'd0, rbuf[0]}, 3);
    check(rbuf[1] == expv[0], "R6 single byte read", {24'd0, rbuf[1]}, {24'd0, expv[0]});
  endtask

  task automatic t_early;
    read_block(8'd3, 1);
    check(oe_after_nack == 1'b0, "R7 early end released", {31'd0, oe_after_nack}, 0);
    check(sda_oe == 1'b0, "R7 idle after stop", {31'd0, sda_oe}, 0);
    wbuf[0] = 8'h9C;
    write_block(8'd4, 8'd1, 1);
    expv[4] = 8'h9C;
    check(ackv[3] == 1'b1, "R7 next transfer acked", {31'd0, ackv[3]}, 1);
    check_regs("R7 next transfer stored");
  endtask

  task automatic t_abort;
    logic a;
    bus_start;
    send_byte(8'hD2, a);
    send_byte(8'd20, a);
    send_byte(8'd2, a);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop;
    check_regs("R9 partial byte dropped");
    wbuf[0] = 8'h5A;
    write_block(8'd20, 8'd1, 1);
    expv[20] = 8'h5A;
    check(ackv[3] == 1'b1, "R9 recovery ack", {31'd0, ackv[3]}, 1);
    check_regs("R9 recovery write");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset;
    t_write;
    t_read;
    t_bad_addr;
    t_zero;
    t_excess;
    t_wrap;
    t_count;
    t_early;
    t_abort;
    check(oe_viol == 0, "R11 oe changed with SCL high", oe_viol, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule